// File: doc/BRIEF.md
# Spike Event Fan-Out Router with Stochastic Release

This block takes spike events from a shared event bus. Each event is only the address of the neuron that fired, and the event's timing is simply the cycle in which it arrives. The block expands each event into a list of synaptic deliveries.

A per-source row in a local routing table points at a run of connection entries. Each entry is one of two kinds:

- A local synapse. It is delivered up to n times. Each repeat passes a pseudo-random draw against a release probability p, and every released repeat carries the entry's target and amplitude q.
- A relay. It forwards the unchanged source address to another level of the routing hierarchy on a separate port.

Input, synapse output and relay output are valid/ready streams:

- A producer holds valid high and keeps its payload unchanged until the consumer raises ready.
- The block itself obeys this rule on both of its output streams.
- The block takes no new event while an expansion is in progress, so back-pressure on either output stalls the expansion and, through a low `in_ready`, the event source.

The table is written through a plain configuration port. The port takes effect only while the block is idle.

Top module: `aer_fanout_router`

## Requirements
- R1: After reset `in_ready` is 1 and both `syn_valid` and `rly_valid` are 0, the release generator holds its seed, and every source row has a count of zero.
- R2: An event is accepted on a cycle where `in_valid` and `in_ready` are both high. From the following cycle `in_ready` stays low until the last output of that event's expansion has completed its handshake, after which it returns high.
- R3: A source row holds a start index (bits 5:0) and an entry count (bits 9:6). Entries start, start+1, … are visited in that order, with the index wrapping modulo 64. A count above 8 is treated as 8, and a count of 0 produces no output.
- R4: An entry holds bit 27 = relay flag, bits 26:19 = target, bits 18:11 = amplitude, bits 10:8 = multiplicity n and bits 7:0 = probability p. A synaptic entry makes n release attempts (n = 0 makes none), and every released attempt emits one `syn` transfer carrying that entry's target and amplitude.
- R5: Release attempts draw on a 16-bit Fibonacci shift register. Its next state is the state shifted left by one with bit 0 = s15^s13^s12^s10, and it is seeded with 0xACE1 at reset. An attempt is released when the register value is below p·256, or whenever p = 255. The register advances exactly once per attempt, so p = 64 releases about a quarter of attempts.
- R6: A relay entry emits exactly one `rly` transfer with `rly_level` = the entry's target bits 1:0 and `rly_src` = the accepted source address. Relay entries ignore n and p and do not advance the release register.
- R7: While an output's valid is high and its ready is low, that valid stays high and its payload stays unchanged, and the release register does not advance.
- R8: A configuration write (`cfg_row` = 1 selects source row `cfg_addr[3:0]`, 0 selects entry `cfg_addr`) takes effect only in a cycle where `in_ready` is high. A write issued during an expansion is discarded.
- R9: `syn_valid` and `rly_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming spike event valid |
| in_ready | output | 1 | Block can accept an event (idle) |
| in_src | input | 4 | Presynaptic source address |
| syn_valid | output | 1 | Released synaptic event valid |
| syn_ready | input | 1 | Consumer accepts synaptic event |
| syn_tgt | output | 8 | Postsynaptic target address |
| syn_amp | output | 8 | Amplitude of the released event |
| rly_valid | output | 1 | Relay event valid |
| rly_ready | input | 1 | Consumer accepts relay event |
| rly_level | output | 2 | Destination hierarchy level |
| rly_src | output | 4 | Unchanged source address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_row | input | 1 | 1 = write source row, 0 = write entry |
| cfg_addr | input | 6 | Row or entry index |
| cfg_wdata | input | 28 | Row or entry contents |

## Verification
The hold properties assume the consumers do not depend on valid being dropped early. They also assume the event source follows the valid/ready rule for `in_src`.

The stimulus respects these assumptions:
- Events and configuration writes are driven half a cycle away from the active edge.
- `in_valid` is held until `in_ready` is seen high.
- Configuration is loaded while the block is idle, except for the deliberate mid-expansion writes that must be discarded.

Ready on both outputs is driven fully open, throttled in a fixed rhythm, or held low for several cycles. This lets the stall rules be observed without ever breaking the handshake contract.

// File: rtl/aerx_pkg.sv
package aerx_pkg;
  parameter int SRC_W  = 4;
  parameter int PTR_W  = 6;
  parameter int TGT_W  = 8;
  parameter int AMP_W  = 8;
  parameter int MULT_W = 3;
  parameter int PROB_W = 8;
  parameter int LVL_W  = 2;
  parameter int CNT_W  = 4;
  parameter int RAND_W = 16;

  localparam int ENT_W = 1 + TGT_W + AMP_W + MULT_W + PROB_W;
  localparam int ROW_W = CNT_W + PTR_W;
  localparam int SRC_N = 1 << SRC_W;
  localparam int ENT_N = 1 << PTR_W;

  typedef struct packed {
    logic              relay;
    logic [TGT_W-1:0]  tgt;
    logic [AMP_W-1:0]  amp;
    logic [MULT_W-1:0] mult;
    logic [PROB_W-1:0] prob;
  } syn_ent_t;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic [PTR_W-1:0] start;
  } src_row_t;

  typedef enum logic {ST_IDLE, ST_RUN} seq_st_e;
endpackage

// File: rtl/aerx_lfsr.sv
module aerx_lfsr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   SEED = 16'hACE1,
  parameter logic [W-1:0]   TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] SAFE_SEED = (SEED == '0) ? W'(1) : SEED;

  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= SAFE_SEED;
    else if (step) state_q <= {state_q[W-2:0], ^(state_q & TAPS)};
  end

  assign value = state_q;

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    value != '0); // R5
  AST_LFSR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(value)); // R7
endmodule

// File: rtl/aerx_table.sv
module aerx_table
  import aerx_pkg::*;
#(
  parameter int MAX_FAN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_open,
  input  logic             cfg_we,
  input  logic             cfg_row,
  input  logic [PTR_W-1:0] cfg_addr,
  input  logic [ENT_W-1:0] cfg_wdata,
  input  logic [SRC_W-1:0] row_sel,
  output src_row_t         row_out,
  input  logic [PTR_W-1:0] ent_sel,
  output syn_ent_t         ent_out
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_FAN);

  src_row_t rows_q [SRC_N];
  syn_ent_t ents_q [ENT_N];
  src_row_t row_raw;
  logic     wr_ok;

  assign wr_ok = cfg_we && wr_open;

  generate
    for (genvar g = 0; g < SRC_N; g++) begin : g_row
      always_ff @(posedge clk) begin
        if (!rst_n)
          rows_q[g] <= '0;
        else if (wr_ok && cfg_row && cfg_addr[SRC_W-1:0] == SRC_W'(g))
          rows_q[g] <= src_row_t'(cfg_wdata[ROW_W-1:0]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_ok && !cfg_row) ents_q[cfg_addr] <= syn_ent_t'(cfg_wdata);
  end

  always_comb begin
    row_raw       = rows_q[row_sel];
    row_out.start = row_raw.start;
    row_out.cnt   = (row_raw.cnt > CAP) ? CAP : row_raw.cnt;
    ent_out       = ents_q[ent_sel];
  end
endmodule

// File: rtl/aerx_seq.sv
module aerx_seq
  import aerx_pkg::*;
#(
  parameter int MAX_FAN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SRC_W-1:0]  in_src,
  output logic [SRC_W-1:0]  row_sel,
  input  src_row_t          row,
  output logic [PTR_W-1:0]  ent_sel,
  input  syn_ent_t          ent,
  input  logic [RAND_W-1:0] rnd,
  output logic              rnd_step,
  output logic              syn_valid,
  input  logic              syn_ready,
  output logic [TGT_W-1:0]  syn_tgt,
  output logic [AMP_W-1:0]  syn_amp,
  output logic              rly_valid,
  input  logic              rly_ready,
  output logic [LVL_W-1:0]  rly_level,
  output logic [SRC_W-1:0]  rly_src,
  output logic              idle
);
  seq_st_e           st_q, st_d;
  logic [SRC_W-1:0]  src_q, src_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [MULT_W-1:0] rep_q, rep_d;
  logic              hit, adv;

  assign hit = (ent.prob == '1) ||
               (rnd < {ent.prob, {(RAND_W-PROB_W){1'b0}}});

  always_comb begin
    st_d      = st_q;
    src_d     = src_q;
    ptr_d     = ptr_q;
    left_d    = left_q;
    rep_d     = rep_q;
    adv       = 1'b0;
    syn_valid = 1'b0;
    rly_valid = 1'b0;
    rnd_step  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (in_valid) begin
          st_d   = ST_RUN;
          src_d  = in_src;
          ptr_d  = row.start;
          left_d = row.cnt;
          rep_d  = '0;
        end
      end
      default: begin
        if (left_q == '0) begin
          st_d = ST_IDLE;
        end else if (ent.relay) begin
          rly_valid = 1'b1;
          adv       = rly_ready;
        end else if (rep_q >= ent.mult) begin
          adv = 1'b1;
        end else begin
          syn_valid = hit;
          if (!hit || syn_ready) begin
            rnd_step = 1'b1;
            rep_d    = rep_q + 1'b1;
          end
        end
      end
    endcase
    if (adv) begin
      ptr_d  = ptr_q + 1'b1;
      left_d = left_q - 1'b1;
      rep_d  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      src_q  <= '0;
      ptr_q  <= '0;
      left_q <= '0;
      rep_q  <= '0;
    end else begin
      st_q   <= st_d;
      src_q  <= src_d;
      ptr_q  <= ptr_d;
      left_q <= left_d;
      rep_q  <= rep_d;
    end
  end

  assign idle      = (st_q == ST_IDLE);
  assign in_ready  = idle;
  assign row_sel   = in_src;
  assign ent_sel   = ptr_q;
  assign syn_tgt   = ent.tgt;
  assign syn_amp   = ent.amp;
  assign rly_level = ent.tgt[LVL_W-1:0];
  assign rly_src   = src_q;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R2
  AST_FAN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= CNT_W'(MAX_FAN)); // R3
  AST_SYN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    syn_valid && !syn_ready |=> syn_valid && $stable(syn_tgt) && $stable(syn_amp)); // R7
  AST_RLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rly_valid && !rly_ready |=> rly_valid && $stable(rly_level) && $stable(rly_src)); // R7
  AST_RELAY_NO_DRAW: assert property (@(posedge clk) disable iff (!rst_n)
    rly_valid |-> !rnd_step); // R6
  AST_ONE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(syn_valid && rly_valid)); // R9
endmodule

// File: rtl/aer_fanout_router.sv
module aer_fanout_router
  import aerx_pkg::*;
#(
  parameter int                MAX_FAN   = 8,
  parameter logic [RAND_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SRC_W-1:0]  in_src,
  output logic              syn_valid,
  input  logic              syn_ready,
  output logic [TGT_W-1:0]  syn_tgt,
  output logic [AMP_W-1:0]  syn_amp,
  output logic              rly_valid,
  input  logic              rly_ready,
  output logic [LVL_W-1:0]  rly_level,
  output logic [SRC_W-1:0]  rly_src,
  input  logic              cfg_we,
  input  logic              cfg_row,
  input  logic [PTR_W-1:0]  cfg_addr,
  input  logic [ENT_W-1:0]  cfg_wdata
);
  logic [SRC_W-1:0]  row_sel;
  logic [PTR_W-1:0]  ent_sel;
  src_row_t          row;
  syn_ent_t          ent;
  logic [RAND_W-1:0] rnd;
  logic              rnd_step;
  logic              idle;

  aerx_lfsr #(.W(RAND_W), .SEED(LFSR_SEED), .TAPS(16'hB400)) u_rng (
    .clk(clk), .rst_n(rst_n), .step(rnd_step), .value(rnd)
  );

  aerx_table #(.MAX_FAN(MAX_FAN)) u_tab (
    .clk(clk), .rst_n(rst_n), .wr_open(idle),
    .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .row_sel(row_sel), .row_out(row), .ent_sel(ent_sel), .ent_out(ent)
  );

  aerx_seq #(.MAX_FAN(MAX_FAN)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
    .row_sel(row_sel), .row(row), .ent_sel(ent_sel), .ent(ent),
    .rnd(rnd), .rnd_step(rnd_step),
    .syn_valid(syn_valid), .syn_ready(syn_ready), .syn_tgt(syn_tgt), .syn_amp(syn_amp),
    .rly_valid(rly_valid), .rly_ready(rly_ready), .rly_level(rly_level), .rly_src(rly_src),
    .idle(idle)
  );
endmodule

// File: tb/aer_fanout_router_tb.sv
module aer_fanout_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_src = '0;
  logic        syn_valid, rly_valid;
  logic        syn_ready = 1'b1, rly_ready = 1'b1;
  logic [7:0]  syn_tgt, syn_amp;
  logic [1:0]  rly_level;
  logic [3:0]  rly_src;
  logic        cfg_we = 1'b0, cfg_row = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [27:0] cfg_wdata = '0;

  aer_fanout_router u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
    .syn_valid(syn_valid), .syn_ready(syn_ready), .syn_tgt(syn_tgt), .syn_amp(syn_amp),
    .rly_valid(rly_valid), .rly_ready(rly_ready), .rly_level(rly_level), .rly_src(rly_src),
    .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, syn_seen = 0, model_hits = 0;
  bit bp = 0, stall = 0, held_syn = 0;
  logic [15:0] held_val;
  logic [16:0] exp_q[$];
  logic [15:0] mlfsr = 16'hACE1;
  logic [5:0]  b_start [16];
  logic [3:0]  b_cnt   [16];
  logic [27:0] b_ent   [64];

  function automatic logic [15:0] rnd_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_row(input int src, input int start, input int cnt, input bit upd);
    @(negedge clk);
    cfg_we = 1; cfg_row = 1; cfg_addr = 6'(src);
    cfg_wdata = {18'b0, 4'(cnt), 6'(start)};
    @(posedge clk); #1 cfg_we = 0;
    if (upd) begin b_start[src] = 6'(start); b_cnt[src] = 4'(cnt); end
  endtask

  task automatic wr_ent(input int idx, input bit rl, input int tgt, input int amp,
                        input int n, input int p, input bit upd);
    @(negedge clk);
    cfg_we = 1; cfg_row = 0; cfg_addr = 6'(idx);
    cfg_wdata = {rl, 8'(tgt), 8'(amp), 3'(n), 8'(p)};
    @(posedge clk); #1 cfg_we = 0;
    if (upd) b_ent[idx] = {rl, 8'(tgt), 8'(amp), 3'(n), 8'(p)};
  endtask

  // Driver: hands an event to the DUT and queues the expected outputs
  task automatic send(input int src);
    int c;
    @(negedge clk);
    in_valid = 1; in_src = 4'(src);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1 in_valid = 0;
    c = (b_cnt[src] > 4'd8) ? 8 : int'(b_cnt[src]);
    for (int k = 0; k < c; k++) begin
      logic [27:0] e;
      e = b_ent[6'(int'(b_start[src]) + k)];
      if (e[27]) exp_q.push_back({1'b1, 6'b0, e[20:19], 4'b0, 4'(src)});
      else begin
        for (int r = 0; r < int'(e[10:8]); r++) begin
          bit h;
          h = (e[7:0] == 8'hFF) || (mlfsr < {e[7:0], 8'h00});
          mlfsr = rnd_next(mlfsr);
          if (h) begin exp_q.push_back({1'b0, e[26:19], e[18:11]}); model_hits++; end
        end
      end
    end
    @(negedge clk);
    chk(!in_ready, "R2", "in_ready low after accept", int'(in_ready), 0);
  endtask

  task automatic wait_idle();
    do @(negedge clk);
    while (!(in_ready && exp_q.size() == 0 && !syn_valid && !rly_valid));
    chk(in_ready, "R2", "in_ready back high after expansion", int'(in_ready), 1);
  endtask

  // Ready generator
  initial forever begin
    @(posedge clk); #2;
    syn_ready = stall ? 1'b0 : (bp ? (cyc % 3 != 0) : 1'b1);
    rly_ready = stall ? 1'b0 : (bp ? (cyc % 4 != 1) : 1'b1);
    cyc++;
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (syn_valid || rly_valid)
        chk(!(syn_valid && rly_valid), "R9", "both valids high", 1, 0);
      if (held_syn)
        chk(syn_valid && {syn_tgt, syn_amp} == held_val, "R7", "stalled syn payload",
            int'({syn_tgt, syn_amp}), int'(held_val));
      held_syn = syn_valid && !syn_ready;
      held_val = {syn_tgt, syn_amp};
      if (syn_valid && syn_ready) begin
        logic [16:0] g;
        g = {1'b0, syn_tgt, syn_amp};
        syn_seen++;
        if (exp_q.size() == 0) chk(0, "R4", "unexpected syn event", int'(g), -1);
        else begin
          logic [16:0] x;
          x = exp_q.pop_front();
          chk(g == x, "R4", "syn event", int'(g), int'(x));
        end
      end
      if (rly_valid && rly_ready) begin
        logic [16:0] g;
        g = {1'b1, 6'b0, rly_level, 4'b0, rly_src};
        if (exp_q.size() == 0) chk(0, "R6", "unexpected relay event", int'(g), -1);
        else begin
          logic [16:0] x;
          x = exp_q.pop_front();
          chk(g == x, "R6", "relay event", int'(g), int'(x));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0, h0;
    for (int i = 0; i < 16; i++) begin b_start[i] = '0; b_cnt[i] = '0; end
    for (int i = 0; i < 64; i++) b_ent[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1, "R1", "in_ready after reset", int'(in_ready), 1);
    chk(!syn_valid && !rly_valid, "R1", "valids after reset", int'({syn_valid, rly_valid}), 0);

    // R3: count 0 from reset yields nothing
    s0 = syn_seen;
    send(0); wait_idle();
    chk(syn_seen == s0 && exp_q.size() == 0, "R3", "zero-count source output", syn_seen - s0, 0);

    // Configure table (idle writes, R8)
    wr_ent(0, 0, 10, 5, 2, 255, 1);
    wr_ent(1, 1, 6, 77, 5, 0, 1);
    wr_ent(2, 0, 20, 9, 3, 128, 1);
    wr_row(1, 0, 3, 1);
    wr_ent(8, 0, 33, 7, 7, 64, 1);
    wr_row(2, 8, 1, 1);
    wr_ent(16, 0, 44, 1, 0, 255, 1);
    wr_ent(17, 0, 45, 2, 4, 0, 1);
    wr_row(3, 16, 2, 1);
    for (int k = 0; k < 9; k++)
      wr_ent(40 + k, k[0], 100 + k, 30 + k, 1 + (k % 7), 200, 1);
    wr_row(4, 40, 12, 1);
    wr_ent(62, 0, 62, 3, 2, 255, 1);
    wr_ent(63, 1, 3, 0, 0, 0, 1);
    wr_row(5, 62, 4, 1);

    // Main function, ready open
    send(1); wait_idle();
    // R4 R5: n=0 and p=0 give no syn events
    s0 = syn_seen;
    send(3); wait_idle();
    chk(syn_seen == s0, "R5", "p=0 / n=0 releases", syn_seen - s0, 0);

    // Back-pressure, back-to-back events, cap and wrap (R3, R7)
    bp = 1;
    send(1); send(4); send(5); send(3); send(4);
    wait_idle();
    bp = 0;

    // R7: hard stall keeps the first syn event on the port
    stall = 1;
    send(1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(syn_valid && syn_tgt == 8'd10, "R7", "stall hold tgt", int'(syn_tgt), 10);
    end
    stall = 0;
    wait_idle();

    // R8: writes during an expansion are discarded
    bp = 1;
    send(4);
    wr_ent(41, 0, 99, 99, 7, 255, 0);
    wr_row(4, 0, 1, 0);
    wait_idle();
    bp = 0;
    s0 = syn_seen; h0 = model_hits;
    send(4); wait_idle();
    chk(syn_seen - s0 == model_hits - h0, "R8", "busy write ignored, syn count",
        syn_seen - s0, model_hits - h0);

    // R5: statistics at p=64 over 700 attempts
    s0 = syn_seen; h0 = model_hits;
    for (int i = 0; i < 100; i++) send(2);
    wait_idle();
    chk(syn_seen - s0 == model_hits - h0, "R5", "release count vs seeded model",
        syn_seen - s0, model_hits - h0);
    chk(syn_seen - s0 >= 120 && syn_seen - s0 <= 230, "R5", "release rate near 1/4",
        syn_seen - s0, 175);

    chk(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule